// File: doc/BRIEF.md
# Loop-History Selected Stride Prefetch Predictor

This block watches the stream of data accesses made by load instructions and predicts the next address each instruction will touch. It is meant to issue prefetches ahead of demand. A direct-mapped table indexed by the low bits of the instruction address holds two stride patterns per instruction. The first pattern tracks accesses inside an inner loop. The second tracks the first access of each new inner-loop pass, which lands after the outer loop has advanced.

A two-outcome history of loop-branch results chooses between the two patterns. Only branches flagged as loop branches feed this history. A resolved loop branch that is not taken, followed by a taken one, means an inner loop has just exited and been re-entered. In that case the outer pattern applies, and it can predict the first access of a pass that a single stride would always miss.

Each pattern has a four-level confidence state machine. A prefetch address and a one-cycle valid pulse appear on the clock edge that samples the access.

Top module: `corr_stride_pf`

State machines:
- The history machine has four states, HS_NN, HS_NT, HS_TN and HS_TT. They are named older outcome first, N for not taken and T for taken. On every resolved loop branch it moves to the state whose older letter is the old newer letter and whose newer letter is the new outcome.
- The confidence machine has four states, CONF_NONE, CONF_LOW, CONF_HIGH and CONF_FULL. A matching stride steps it up one level and it saturates at CONF_FULL. A mismatch sends it to CONF_NONE from any state.

## Requirements
- R1: While reset is asserted and on the first edge after it, pf_valid is 0, every table entry is empty and the history state is HS_NN (bits 00).
- R2: An access whose index entry is empty allocates that entry with both patterns holding the access address, a stride of 0 and CONF_NONE, and it issues no prefetch.
- R3: Each resolved loop branch shifts its outcome into a 2-bit history, with bit 0 the newest and 1 meaning taken. A history of exactly 01 (older not taken, newer taken) selects the outer pattern, and every other value selects the inner pattern.
- R4: A resolved branch with br_loop low leaves the history unchanged.
- R5: On a hit, the observed stride is the access address minus the selected pattern's previous address. If it equals the stored stride, the confidence steps up one level. Otherwise the stored stride is replaced by the observed one and the confidence returns to CONF_NONE.
- R6: pf_valid rises in the cycle after an access exactly when that access hit, matched, and left its pattern at CONF_HIGH or CONF_FULL. pf_addr is then the access address plus the stored stride. pf_valid is 0 in every other cycle.
- R7: An inner-selected access updates only the inner pattern. An outer-selected access updates the outer pattern's address, stride and confidence, and moves the inner previous address to the access address without touching the inner stride or confidence.
- R8: Confidence saturates at CONF_FULL, so a run of matching accesses keeps issuing prefetches.
- R9: An access whose tag (the instruction address bits above the index) differs from the stored tag reallocates the entry as in R2.
- R10: An access in the same cycle as a resolved loop branch uses the history from before that branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_pc | input | PC_W | Instruction address of the access |
| acc_addr | input | ADDR_W | Data address of the access |
| br_valid | input | 1 | A branch resolves this cycle |
| br_loop | input | 1 | The resolving branch is a loop branch |
| br_taken | input | 1 | Outcome of the resolving branch, 1 taken |
| pf_valid | output | 1 | Prefetch request pulse |
| pf_addr | output | ADDR_W | Predicted prefetch address |

## Verification
The bench builds the block with IDX_W = 3, which gives eight entries, and with 32-bit instruction and data addresses. The small index lets two instruction addresses, 0x10 and 0x18, share one entry, which makes tag replacement reachable. A nested-loop access pattern with 64-byte outer and 4-byte inner steps drives the outer pattern to confidence. Its first-of-pass prediction can then be compared with what a single stride would give. Non-loop branches and a branch in the same cycle as an access are placed so that a wrong history would change the predicted pattern.

// File: rtl/corr_stride_pkg.sv
package corr_stride_pkg;

    typedef enum logic [1:0] {
        CONF_NONE = 2'd0,
        CONF_LOW  = 2'd1,
        CONF_HIGH = 2'd2,
        CONF_FULL = 2'd3
    } conf_t;

    // history state, older outcome in bit 1, newer in bit 0
    typedef enum logic [1:0] {
        HS_NN = 2'b00,
        HS_NT = 2'b01,
        HS_TN = 2'b10,
        HS_TT = 2'b11
    } hist_t;

    typedef enum logic {
        SEL_INNER = 1'b0,
        SEL_OUTER = 1'b1
    } sel_t;

endpackage

// File: rtl/corr_hist.sv
module corr_hist
    import corr_stride_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       br_valid,
    input  logic       br_loop,
    input  logic       br_taken,
    output sel_t       sel_o,
    output logic [1:0] hist_o
);

    hist_t st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        if (br_valid && br_loop) begin
            unique case (st_q)
                HS_NN, HS_TN: st_nx = br_taken ? HS_NT : HS_NN;
                HS_NT, HS_TT: st_nx = br_taken ? HS_TT : HS_TN;
                default:      st_nx = HS_NN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_NN;
        else        st_q <= st_nx;
    end

    always_comb begin
        unique case (st_q)
            HS_NT:   sel_o = SEL_OUTER;
            default: sel_o = SEL_INNER;
        endcase
        hist_o = st_q;
    end

endmodule

// File: rtl/corr_conf.sv
module corr_conf
    import corr_stride_pkg::*;
(
    input  conf_t cur_i,
    input  logic  match_i,
    output conf_t nxt_o,
    output logic  issue_o
);

    always_comb begin
        nxt_o = CONF_NONE;
        if (match_i) begin
            unique case (cur_i)
                CONF_NONE: nxt_o = CONF_LOW;
                CONF_LOW:  nxt_o = CONF_HIGH;
                CONF_HIGH: nxt_o = CONF_FULL;
                CONF_FULL: nxt_o = CONF_FULL;
                default:   nxt_o = CONF_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (nxt_o)
            CONF_HIGH, CONF_FULL: issue_o = match_i;
            default:              issue_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/corr_stride_pf.sv
module corr_stride_pf
    import corr_stride_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              br_valid,
    input  logic              br_loop,
    input  logic              br_taken,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = PC_W - IDX_W;

    logic [ENTRIES-1:0] ent_vld;
    logic [TAG_W-1:0]   ent_tag   [ENTRIES];
    logic [ADDR_W-1:0]  in_prev   [ENTRIES];
    logic [ADDR_W-1:0]  in_stride [ENTRIES];
    conf_t              in_conf   [ENTRIES];
    logic [ADDR_W-1:0]  out_prev  [ENTRIES];
    logic [ADDR_W-1:0]  out_stride[ENTRIES];
    conf_t              out_conf  [ENTRIES];

    sel_t               sel;
    logic [1:0]         hist_bits;

    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic               hit;
    logic               use_outer;
    logic [ADDR_W-1:0]  cur_prev, cur_stride, obs_stride;
    conf_t              cur_conf, nxt_conf;
    logic               match, issue;

    corr_hist u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_valid (br_valid),
        .br_loop  (br_loop),
        .br_taken (br_taken),
        .sel_o    (sel),
        .hist_o   (hist_bits)
    );

    assign idx       = acc_pc[IDX_W-1:0];
    assign tag       = acc_pc[PC_W-1:IDX_W];
    assign hit       = ent_vld[idx] && (ent_tag[idx] == tag);
    assign use_outer = (sel == SEL_OUTER);

    always_comb begin
        if (use_outer) begin
            cur_prev   = out_prev[idx];
            cur_stride = out_stride[idx];
            cur_conf   = out_conf[idx];
        end else begin
            cur_prev   = in_prev[idx];
            cur_stride = in_stride[idx];
            cur_conf   = in_conf[idx];
        end
        obs_stride = acc_addr - cur_prev;
        match      = (obs_stride == cur_stride);
    end

    corr_conf u_conf (
        .cur_i   (cur_conf),
        .match_i (match),
        .nxt_o   (nxt_conf),
        .issue_o (issue)
    );

    // table state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_vld <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_tag[i]    <= '0;
                in_prev[i]    <= '0;
                in_stride[i]  <= '0;
                in_conf[i]    <= CONF_NONE;
                out_prev[i]   <= '0;
                out_stride[i] <= '0;
                out_conf[i]   <= CONF_NONE;
            end
        end else if (acc_valid) begin
            if (!hit) begin
                ent_vld[idx]    <= 1'b1;
                ent_tag[idx]    <= tag;
                in_prev[idx]    <= acc_addr;
                in_stride[idx]  <= '0;
                in_conf[idx]    <= CONF_NONE;
                out_prev[idx]   <= acc_addr;
                out_stride[idx] <= '0;
                out_conf[idx]   <= CONF_NONE;
            end else if (use_outer) begin
                out_prev[idx]   <= acc_addr;
                out_stride[idx] <= obs_stride;
                out_conf[idx]   <= nxt_conf;
                in_prev[idx]    <= acc_addr;
            end else begin
                in_prev[idx]    <= acc_addr;
                in_stride[idx]  <= obs_stride;
                in_conf[idx]    <= nxt_conf;
            end
        end
    end

    // prefetch outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= acc_valid && hit && issue;
            if (acc_valid && hit && issue) pf_addr <= acc_addr + cur_stride;
        end
    end

endmodule

// File: rtl/corr_stride_chk.sv
module corr_stride_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       br_valid,
    input logic       br_loop,
    input logic       br_taken,
    input logic       pf_valid,
    input logic [1:0] hist,
    input logic       hit
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pf_valid && hist == 2'b00));

    assert_miss_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !hit) |=> !pf_valid);

    assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_loop) |=> (hist == {$past(hist[0]), $past(br_taken)}));

    assert_hist_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_valid && br_loop) |=> $stable(hist));

    assert_pf_follows_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(acc_valid));

endmodule

bind corr_stride_pf corr_stride_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .br_valid  (br_valid),
    .br_loop   (br_loop),
    .br_taken  (br_taken),
    .pf_valid  (pf_valid),
    .hist      (hist_bits),
    .hit       (hit)
);

// File: tb/corr_stride_pf_test.sv
module corr_stride_pf_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic [31:0] acc_pc, acc_addr;
    logic        br_valid, br_loop, br_taken;
    logic        pf_valid;
    logic [31:0] pf_addr;

    always #10 clk = ~clk;

    corr_stride_pf #(.PC_W(32), .ADDR_W(32), .IDX_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_pc(acc_pc),
        .acc_addr(acc_addr), .br_valid(br_valid), .br_loop(br_loop),
        .br_taken(br_taken), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    typedef struct {
        logic        pf;
        logic [31:0] addr;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    localparam logic [31:0] PC_A = 32'h10;
    localparam logic [31:0] PC_B = 32'h21;
    localparam logic [31:0] PC_C = 32'h18;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        acc_valid = 1'b0; br_valid = 1'b0; br_loop = 1'b0; br_taken = 1'b0;
    endtask

    // driver: drive one access, push its expected result
    task automatic access(input logic [31:0] pc, input logic [31:0] addr,
                          input logic pf, input logic [31:0] eaddr, input string req,
                          input bit with_br = 1'b0, input bit br_t = 1'b0);
        exp_t e;
        @(negedge clk);
        e.pf = pf; e.addr = eaddr; e.req = req;
        q.push_back(e);
        acc_valid = 1'b1; acc_pc = pc; acc_addr = addr;
        if (with_br) begin
            br_valid = 1'b1; br_loop = 1'b1; br_taken = br_t;
        end
        @(posedge clk); #1;
        clear_in();
    endtask

    task automatic branch(input bit is_loop, input bit t);
        @(negedge clk);
        br_valid = 1'b1; br_loop = is_loop; br_taken = t;
        @(posedge clk); #1;
        clear_in();
    endtask

    // monitor: compare one cycle after each sampled access
    always @(posedge clk) begin
        exp_t e;
        if (rst_n && acc_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R6", "scoreboard empty", 32'd0, 32'd1);
            end else begin
                e = q.pop_front();
                #2;
                check(pf_valid == e.pf, e.req, "pf_valid", {31'd0, pf_valid}, {31'd0, e.pf});
                if (e.pf) check(pf_addr == e.addr, e.req, "pf_addr", pf_addr, e.addr);
            end
        end else if (rst_n) begin
            #2;
            check(pf_valid == 1'b0, "R6", "idle pf_valid", {31'd0, pf_valid}, 32'd0);
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_pc = '0; acc_addr = '0;
        clear_in();
        repeat (3) @(negedge clk);
        check(pf_valid == 1'b0, "R1", "pf_valid in reset", {31'd0, pf_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pf_valid == 1'b0, "R1", "pf_valid after reset", {31'd0, pf_valid}, 32'd0);

        // single stride, history 00 -> inner pattern
        access(PC_A, 100, 0, 0,   "R2");
        access(PC_A, 104, 0, 0,   "R5");
        access(PC_A, 108, 0, 0,   "R5");
        access(PC_A, 112, 1, 116, "R6");
        access(PC_A, 116, 1, 120, "R8");
        access(PC_A, 120, 1, 124, "R8");
        access(PC_A, 124, 1, 128, "R8");
        access(PC_A, 200, 0, 0,   "R5");
        access(PC_A, 276, 0, 0,   "R5");

        // aliasing index with a different tag: R9
        access(PC_C, 352, 0, 0, "R9");
        access(PC_C, 362, 0, 0, "R9");

        // nested loop: outer step 64, inner step 4
        branch(1, 1); branch(1, 1);
        access(PC_B, 1000, 0, 0, "R2");
        branch(1, 1); access(PC_B, 1004, 0, 0, "R5");
        branch(1, 1); access(PC_B, 1008, 0, 0, "R5");
        branch(1, 0); branch(1, 1);
        access(PC_B, 1064, 0, 0, "R7");
        branch(1, 1); access(PC_B, 1068, 1, 1072, "R7");
        branch(1, 1); access(PC_B, 1072, 1, 1076, "R6");
        branch(1, 0); branch(1, 1);
        access(PC_B, 1128, 0, 0, "R3");
        branch(1, 1); access(PC_B, 1132, 1, 1136, "R7");
        branch(1, 1); access(PC_B, 1136, 1, 1140, "R6");
        branch(1, 0); branch(1, 1);
        access(PC_B, 1192, 1, 1256, "R3");
        branch(1, 1); access(PC_B, 1196, 1, 1200, "R7");
        branch(1, 1); access(PC_B, 1200, 1, 1204, "R6");
        branch(1, 0); branch(1, 1);
        branch(0, 0); branch(0, 0);
        access(PC_B, 1256, 1, 1320, "R4");
        access(PC_B, 1260, 0, 0, "R10", 1'b1, 1'b1);
        access(PC_B, 1264, 1, 1268, "R10");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule